// File: doc/BRIEF.md
# Register Redirection and Sub-Element Swizzle Unit

This block turns a scalar operand register number into the physical register that a given element and sub-element of a vector operation should touch. A small key-value table, addressed by register number together with an integer/float flag, supplies a 7-bit target register, a vector/scalar marker and an element width override. A second small table, keyed the same way, supplies four 2-bit sub-element reorder indices.

For each lookup the unit takes the operand number, its register class, whether it is a destination, the element index, the sub-element index and the sub-vector length code. It then returns the physical register index, the width code, the vector marker and an illegal-instruction flag. The flag is raised when a destination reorder is not a permutation over the sub-elements in use. Both tables are written through simple synchronous write ports. The lookup path is purely combinational.

Top module: `rsw_redirect_unit`

## Requirements
- R1: After reset both tables are empty, so every lookup misses: phys_o equals the operand number, width_o is 00, vec_o and illegal_o are 0.
- R2: On a miss in the register table, phys_o is the operand number zero-extended to 7 bits, width_o is 00 and vec_o is 0.
- R3: A lookup hits only an entry whose register number and integer/float flag both equal the operand's. A hit on an entry whose vector marker is clear gives phys_o equal to the entry's target for every element and sub-element index, with vec_o 0.
- R4: The sub-vector length code c (subvl_i) means SUBVL = c+1. A hit on a vector entry gives vec_o 1 and phys_o = (target + elem_i*SUBVL + off) mod 128, where off is sub_i unless R7 applies.
- R5: width_o carries the hit entry's width code: 00 default register width, 01 8-bit, 10 16-bit, 11 32-bit.
- R6: When several valid entries of a table match, the entry with the lowest index is used.
- R7: For a destination (op_is_dst_i 1) with a swizzle-table hit and SUBVL of 2, 3 or 4, off is the swizzle index held in bits [2*sub_i+1 : 2*sub_i] of the entry's select field. With SUBVL 1 or no swizzle hit, off is sub_i.
- R8: For a source (op_is_dst_i 0), off is always sub_i, even when a swizzle entry matches.
- R9: illegal_o is 1 exactly when the operand is a destination, the swizzle table hits, SUBVL is at least 2 and two of the first SUBVL swizzle indices are equal; sources never raise it.
- R10: A table write with its valid input 0 removes the addressed entry, and a write with valid 1 replaces the whole entry; both take effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rt_we_i | input | 1 | Register table write enable |
| rt_idx_i | input | 2 | Register table entry to write |
| rt_valid_i | input | 1 | Valid bit written to the entry |
| rt_key_i | input | 5 | Scalar register number used as key |
| rt_is_int_i | input | 1 | Key class: 1 integer, 0 float |
| rt_isvec_i | input | 1 | Vector marker of the entry |
| rt_width_i | input | 2 | Width override code |
| rt_target_i | input | 7 | Physical target register |
| sw_we_i | input | 1 | Swizzle table write enable |
| sw_idx_i | input | 2 | Swizzle table entry to write |
| sw_valid_i | input | 1 | Valid bit written to the entry |
| sw_key_i | input | 5 | Scalar register number used as key |
| sw_is_int_i | input | 1 | Key class: 1 integer, 0 float |
| sw_sel_i | input | 8 | Four 2-bit reorder indices, index k at bits [2k+1:2k] |
| op_reg_i | input | 5 | Operand register number |
| op_is_int_i | input | 1 | Operand class: 1 integer, 0 float |
| op_is_dst_i | input | 1 | Operand is a destination |
| elem_i | input | 6 | Element index |
| sub_i | input | 2 | Sub-element index |
| subvl_i | input | 2 | Sub-vector length code, SUBVL = code+1 |
| phys_o | output | 7 | Physical register index |
| width_o | output | 2 | Width code |
| vec_o | output | 1 | Operand advances per element |
| illegal_o | output | 1 | Illegal destination swizzle |

## Verification
The assertions take for granted that the operand inputs are steady around each rising clock edge and that table writes land only on that edge. They also assume the scalar-stability property is only meaningful when no register table write happened in the previous cycle. The bench keeps to this by changing operand inputs only between writes and by issuing writes from the falling edge with enables dropped just after the rising edge. Sweeps cover every operand number, both register classes, both roles, every sub-element index and SUBVL code, and element indices that include zero and the largest value, so the 7-bit wrap is reached.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  localparam int RN_W  = 5;            // scalar register number
  localparam int PR_W  = 7;            // physical register index
  localparam int SV_W  = 2;            // sub-vector code / sub index
  localparam int LANES = 1 << SV_W;    // max sub-elements
  localparam int KEY_W = RN_W + 1;     // {is_int, reg}

  typedef enum logic [1:0] {
    WID_DEF = 2'b00,
    WID_8   = 2'b01,
    WID_16  = 2'b10,
    WID_32  = 2'b11
  } wid_e;
endpackage

// File: rtl/rsw_prio_match.sv
module rsw_prio_match #(
  parameter int N  = 4,
  parameter int KW = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         vld_i,
  input  logic [N-1:0][KW-1:0] keys_i,
  input  logic [KW-1:0]        key_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld_i[g] && (keys_i[g] == key_i);
  end

  // scan downward so the lowest matching index is kept
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rsw_dup_check.sv
module rsw_dup_check #(
  parameter int LANES = 4,
  localparam int IW = $clog2(LANES)
) (
  input  logic [LANES-1:0][IW-1:0] sel_i,
  input  logic [IW-1:0]            code_i,  // lanes in use = code_i + 1
  output logic                     dup_o
);
  logic [LANES*LANES-1:0] pair;

  for (genvar a = 0; a < LANES; a++) begin : g_a
    for (genvar b = 0; b < LANES; b++) begin : g_b
      if (b > a) begin : g_pair
        assign pair[a*LANES+b] = (sel_i[a] == sel_i[b]) && (IW'(b) <= code_i);
      end else begin : g_none
        assign pair[a*LANES+b] = 1'b0;
      end
    end
  end

  assign dup_o = |pair;
endmodule

// File: rtl/rsw_addr_gen.sv
module rsw_addr_gen #(
  parameter int PR_W   = 7,
  parameter int ELEM_W = 6,
  parameter int SV_W   = 2
) (
  input  logic [PR_W-1:0]   base_i,
  input  logic              vec_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [SV_W-1:0]   code_i,
  input  logic [SV_W-1:0]   off_i,
  output logic [PR_W-1:0]   phys_o
);
  localparam int SW = PR_W + ELEM_W + SV_W + 2;

  logic [SW-1:0] stride;
  logic [SW-1:0] sum;

  assign stride = SW'(code_i) + SW'(1);
  assign sum    = SW'(base_i) + SW'(elem_i) * stride + SW'(off_i);
  assign phys_o = vec_i ? sum[PR_W-1:0] : base_i;
endmodule

// File: rtl/rsw_redirect_unit.sv
module rsw_redirect_unit
  import rsw_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int ELEM_W = 6,
  localparam int IW    = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int SEL_W = LANES * SV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rt_we_i,
  input  logic [IW-1:0]     rt_idx_i,
  input  logic              rt_valid_i,
  input  logic [RN_W-1:0]   rt_key_i,
  input  logic              rt_is_int_i,
  input  logic              rt_isvec_i,
  input  logic [1:0]        rt_width_i,
  input  logic [PR_W-1:0]   rt_target_i,
  input  logic              sw_we_i,
  input  logic [IW-1:0]     sw_idx_i,
  input  logic              sw_valid_i,
  input  logic [RN_W-1:0]   sw_key_i,
  input  logic              sw_is_int_i,
  input  logic [SEL_W-1:0]  sw_sel_i,
  input  logic [RN_W-1:0]   op_reg_i,
  input  logic              op_is_int_i,
  input  logic              op_is_dst_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [SV_W-1:0]   sub_i,
  input  logic [SV_W-1:0]   subvl_i,
  output logic [PR_W-1:0]   phys_o,
  output logic [1:0]        width_o,
  output logic              vec_o,
  output logic              illegal_o
);
  // register table
  logic [N_ENT-1:0]            rt_vld_q;
  logic [N_ENT-1:0][KEY_W-1:0] rt_key_q;
  logic [N_ENT-1:0]            rt_vec_q;
  logic [N_ENT-1:0][1:0]       rt_wid_q;
  logic [N_ENT-1:0][PR_W-1:0]  rt_tgt_q;
  // swizzle table
  logic [N_ENT-1:0]            sw_vld_q;
  logic [N_ENT-1:0][KEY_W-1:0] sw_key_q;
  logic [N_ENT-1:0][SEL_W-1:0] sw_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rt_vld_q <= '0;
      rt_key_q <= '0;
      rt_vec_q <= '0;
      rt_wid_q <= '0;
      rt_tgt_q <= '0;
    end else if (rt_we_i) begin
      rt_vld_q[rt_idx_i] <= rt_valid_i;
      rt_key_q[rt_idx_i] <= {rt_is_int_i, rt_key_i};
      rt_vec_q[rt_idx_i] <= rt_isvec_i;
      rt_wid_q[rt_idx_i] <= rt_width_i;
      rt_tgt_q[rt_idx_i] <= rt_target_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_vld_q <= '0;
      sw_key_q <= '0;
      sw_sel_q <= '0;
    end else if (sw_we_i) begin
      sw_vld_q[sw_idx_i] <= sw_valid_i;
      sw_key_q[sw_idx_i] <= {sw_is_int_i, sw_key_i};
      sw_sel_q[sw_idx_i] <= sw_sel_i;
    end
  end

  logic [KEY_W-1:0] op_key;
  assign op_key = {op_is_int_i, op_reg_i};

  logic          rt_hit, sw_hit;
  logic [IW-1:0] rt_sel_idx, sw_sel_idx;

  rsw_prio_match #(.N(N_ENT), .KW(KEY_W)) u_rt_match (
    .vld_i (rt_vld_q),
    .keys_i(rt_key_q),
    .key_i (op_key),
    .hit_o (rt_hit),
    .idx_o (rt_sel_idx)
  );

  rsw_prio_match #(.N(N_ENT), .KW(KEY_W)) u_sw_match (
    .vld_i (sw_vld_q),
    .keys_i(sw_key_q),
    .key_i (op_key),
    .hit_o (sw_hit),
    .idx_o (sw_sel_idx)
  );

  // selected register entry, miss falls back to pass-through
  logic [PR_W-1:0] rt_tgt_sel;
  logic [PR_W-1:0] base;
  logic            vec_sel;
  wid_e            wid_sel;

  assign rt_tgt_sel = rt_tgt_q[rt_sel_idx];
  assign base       = rt_hit ? rt_tgt_sel : PR_W'(op_reg_i);
  assign vec_sel    = rt_hit && rt_vec_q[rt_sel_idx];
  assign wid_sel    = rt_hit ? wid_e'(rt_wid_q[rt_sel_idx]) : WID_DEF;

  // swizzle
  logic [LANES-1:0][SV_W-1:0] swz;
  logic                       swz_on;
  logic                       swz_dup;
  logic [SV_W-1:0]            off;

  assign swz    = sw_sel_q[sw_sel_idx];
  assign swz_on = sw_hit && (subvl_i != '0);
  assign off    = (op_is_dst_i && swz_on) ? swz[sub_i] : sub_i;

  rsw_dup_check #(.LANES(LANES)) u_dup (
    .sel_i (swz),
    .code_i(subvl_i),
    .dup_o (swz_dup)
  );

  rsw_addr_gen #(.PR_W(PR_W), .ELEM_W(ELEM_W), .SV_W(SV_W)) u_addr (
    .base_i(base),
    .vec_i (vec_sel),
    .elem_i(elem_i),
    .code_i(subvl_i),
    .off_i (off),
    .phys_o(phys_o)
  );

  assign width_o   = wid_sel;
  assign vec_o     = vec_sel;
  assign illegal_o = op_is_dst_i && swz_on && swz_dup;
endmodule

// File: rtl/rsw_redirect_chk.sv
module rsw_redirect_chk
  import rsw_pkg::*;
#(
  parameter int IW     = 2,
  parameter int ELEM_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rt_we_i,
  input logic [IW-1:0]     rt_idx_i,
  input logic              rt_valid_i,
  input logic [RN_W-1:0]   rt_key_i,
  input logic              rt_is_int_i,
  input logic              rt_isvec_i,
  input logic [1:0]        rt_width_i,
  input logic [RN_W-1:0]   op_reg_i,
  input logic              op_is_int_i,
  input logic              op_is_dst_i,
  input logic [ELEM_W-1:0] elem_i,
  input logic [SV_W-1:0]   sub_i,
  input logic [SV_W-1:0]   subvl_i,
  input logic [PR_W-1:0]   phys_o,
  input logic [1:0]        width_o,
  input logic              vec_o,
  input logic              illegal_o,
  input logic              rt_hit,
  input logic              sw_hit,
  input logic [PR_W-1:0]   rt_tgt_sel
);
  // R2
  miss_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rt_hit |-> (phys_o == PR_W'(op_reg_i)) && (width_o == 2'b00) && !vec_o);

  // R9
  illegal_dst_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> op_is_dst_i && sw_hit && (subvl_i != '0));

  // R8
  src_in_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o && !op_is_dst_i && elem_i == '0) |-> (phys_o == PR_W'(rt_tgt_sel + PR_W'(sub_i))));

  // R3
  scalar_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_hit && !vec_o && $stable(op_reg_i) && $stable(op_is_int_i) && !$past(rt_we_i))
      |-> $stable(phys_o));

  // R10
  write_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rt_we_i && rt_valid_i && rt_idx_i == '0)
      && ({op_is_int_i, op_reg_i} == {$past(rt_is_int_i), $past(rt_key_i)}))
      |-> rt_hit && (vec_o == $past(rt_isvec_i)) && (width_o == $past(rt_width_i)));
endmodule

bind rsw_redirect_unit rsw_redirect_chk #(.IW(IW), .ELEM_W(ELEM_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rt_we_i    (rt_we_i),
  .rt_idx_i   (rt_idx_i),
  .rt_valid_i (rt_valid_i),
  .rt_key_i   (rt_key_i),
  .rt_is_int_i(rt_is_int_i),
  .rt_isvec_i (rt_isvec_i),
  .rt_width_i (rt_width_i),
  .op_reg_i   (op_reg_i),
  .op_is_int_i(op_is_int_i),
  .op_is_dst_i(op_is_dst_i),
  .elem_i     (elem_i),
  .sub_i      (sub_i),
  .subvl_i    (subvl_i),
  .phys_o     (phys_o),
  .width_o    (width_o),
  .vec_o      (vec_o),
  .illegal_o  (illegal_o),
  .rt_hit     (rt_hit),
  .sw_hit     (sw_hit),
  .rt_tgt_sel (rt_tgt_sel)
);

// File: tb/rsw_redirect_unit_tb.sv
module rsw_redirect_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       rt_we = 0, rt_valid = 0, rt_is_int = 0, rt_isvec = 0;
  logic [1:0] rt_idx = 0, rt_width = 0;
  logic [4:0] rt_key = 0;
  logic [6:0] rt_target = 0;
  logic       sw_we = 0, sw_valid = 0, sw_is_int = 0;
  logic [1:0] sw_idx = 0;
  logic [4:0] sw_key = 0;
  logic [7:0] sw_sel = 0;
  logic [4:0] op_reg = 0;
  logic       op_is_int = 0, op_is_dst = 0;
  logic [5:0] elem = 0;
  logic [1:0] sub = 0, subvl = 0;
  logic [6:0] phys;
  logic [1:0] width;
  logic       vec, illegal;

  rsw_redirect_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rt_we_i(rt_we), .rt_idx_i(rt_idx), .rt_valid_i(rt_valid), .rt_key_i(rt_key),
    .rt_is_int_i(rt_is_int), .rt_isvec_i(rt_isvec), .rt_width_i(rt_width),
    .rt_target_i(rt_target),
    .sw_we_i(sw_we), .sw_idx_i(sw_idx), .sw_valid_i(sw_valid), .sw_key_i(sw_key),
    .sw_is_int_i(sw_is_int), .sw_sel_i(sw_sel),
    .op_reg_i(op_reg), .op_is_int_i(op_is_int), .op_is_dst_i(op_is_dst),
    .elem_i(elem), .sub_i(sub), .subvl_i(subvl),
    .phys_o(phys), .width_o(width), .vec_o(vec), .illegal_o(illegal)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // bench-side table model
  bit       m_rv[4];
  int       m_rk[4], m_rtgt[4], m_rwid[4];
  bit       m_rvec[4];
  bit       m_sv[4];
  int       m_sk[4];
  bit [7:0] m_ssel[4];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (reg %0d int %0d dst %0d elem %0d sub %0d code %0d)",
               req, act, exp, op_reg, op_is_int, op_is_dst, elem, sub, subvl);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic wr_rt(int idx, bit v, int key, bit isint, bit isvec, int wid, int tgt);
    @(negedge clk);
    rt_we = 1; rt_idx = 2'(idx); rt_valid = v; rt_key = 5'(key); rt_is_int = isint;
    rt_isvec = isvec; rt_width = 2'(wid); rt_target = 7'(tgt);
    @(posedge clk); #1;
    rt_we = 0;
    m_rv[idx] = v; m_rk[idx] = key + (isint ? 32 : 0); m_rvec[idx] = isvec;
    m_rwid[idx] = wid; m_rtgt[idx] = tgt;
  endtask

  task automatic wr_sw(int idx, bit v, int key, bit isint, bit [7:0] sel);
    @(negedge clk);
    sw_we = 1; sw_idx = 2'(idx); sw_valid = v; sw_key = 5'(key); sw_is_int = isint;
    sw_sel = sel;
    @(posedge clk); #1;
    sw_we = 0;
    m_sv[idx] = v; m_sk[idx] = key + (isint ? 32 : 0); m_ssel[idx] = sel;
  endtask

  task automatic drive(int r, bit i, bit d, int e, int s, int c);
    op_reg = 5'(r); op_is_int = i; op_is_dst = d; elem = 6'(e); sub = 2'(s); subvl = 2'(c);
    #1;
  endtask

  // expected values straight from the requirement text
  task automatic expect_out(output int ephys, output int ewid, output int evec,
                            output int eill, output string preq);
    int key = int'(op_reg) + (op_is_int ? 32 : 0);
    int rh = -1, sh = -1, svl = int'(subvl) + 1, off = int'(sub);
    bit swon, dup = 0;
    for (int k = 3; k >= 0; k--) begin
      if (m_rv[k] && m_rk[k] == key) rh = k;
      if (m_sv[k] && m_sk[k] == key) sh = k;
    end
    swon = (sh >= 0) && (svl >= 2);
    if (swon) begin
      for (int a = 0; a < svl; a++)
        for (int b = a + 1; b < svl; b++)
          if (m_ssel[sh][2*a +: 2] == m_ssel[sh][2*b +: 2]) dup = 1;
      if (op_is_dst) off = int'(m_ssel[sh][2*int'(sub) +: 2]);
    end
    eill = (op_is_dst && swon && dup) ? 1 : 0;
    if (rh < 0) begin
      ephys = int'(op_reg); ewid = 0; evec = 0; preq = "R2";
    end else if (!m_rvec[rh]) begin
      ephys = m_rtgt[rh]; ewid = m_rwid[rh]; evec = 0; preq = "R3";
    end else begin
      ephys = (m_rtgt[rh] + int'(elem) * svl + off) % 128;
      ewid = m_rwid[rh]; evec = 1;
      if (swon && op_is_dst) preq = "R7";
      else if (sh >= 0 && svl >= 2) preq = "R8";
      else preq = "R4";
    end
  endtask

  task automatic check_now(string force_req);
    int ep, ew, ev, ei;
    string pr;
    expect_out(ep, ew, ev, ei, pr);
    if (force_req != "") pr = force_req;
    chk(pr, int'(phys), ep);
    chk((force_req != "") ? force_req : "R5", int'(width), ew);
    chk((force_req != "") ? force_req : "R3", int'(vec), ev);
    chk((force_req != "") ? force_req : "R9", int'(illegal), ei);
  endtask

  task automatic sweep(string force_req);
    int elems[4] = '{0, 1, 5, 63};
    for (int r = 0; r < 32; r++)
      for (int i = 0; i < 2; i++)
        for (int d = 0; d < 2; d++)
          for (int e = 0; e < 4; e++)
            for (int s = 0; s < 4; s++)
              for (int c = 0; c < 4; c++) begin
                drive(r, i[0], d[0], elems[e], s, c);
                check_now(force_req);
              end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      m_rv[k] = 0; m_sv[k] = 0; m_rk[k] = 0; m_sk[k] = 0;
      m_rtgt[k] = 0; m_rwid[k] = 0; m_rvec[k] = 0; m_ssel[k] = 0;
    end
    #1;
    // R1: outputs during reset, then an empty-table sweep
    drive(7, 1, 1, 3, 2, 3);
    check_now("R1");
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    sweep("R1");

    // config A: int x5 vector, float x5 scalar, int x9 vector near the top, duplicate int x5
    wr_rt(0, 1, 5, 1, 1, 1, 20);
    wr_rt(1, 1, 5, 0, 0, 2, 100);
    wr_rt(2, 1, 9, 1, 1, 3, 120);
    wr_rt(3, 1, 5, 1, 0, 0, 50);
    wr_sw(0, 1, 5, 1, 8'h63);   // indices 3,0,2,1
    wr_sw(1, 1, 9, 1, 8'h85);   // indices 1,1,0,2
    wr_sw(2, 1, 5, 0, 8'hAA);   // indices 2,2,2,2
    wr_sw(3, 1, 5, 1, 8'h1B);   // shadowed by entry 0
    sweep("");

    // R6: entry 0 wins over entry 3 for int x5
    drive(5, 1, 0, 0, 0, 0);
    chk("R6", int'(phys), 20);
    chk("R6", int'(width), 1);
    // R6: swizzle entry 0 wins over entry 3 (dst, SUBVL 4, sub 0 -> index 3)
    drive(5, 1, 1, 0, 0, 3);
    chk("R6", int'(phys), 23);
    // R4: wrap at 128 (120 + 63*4 + 3 = 375 -> 119), source in order
    drive(9, 1, 0, 63, 3, 3);
    chk("R4", int'(phys), 119);

    // R10: invalidate entry 0, int x5 falls to scalar entry 3
    wr_rt(0, 0, 5, 1, 1, 1, 20);
    drive(5, 1, 0, 7, 1, 2);
    chk("R10", int'(phys), 50);
    chk("R10", int'(vec), 0);
    chk("R10", int'(width), 0);
    // R10: overwrite entry 3 fully
    wr_rt(3, 1, 5, 1, 1, 2, 90);
    drive(5, 1, 0, 2, 1, 1);
    chk("R10", int'(phys), 95);
    chk("R10", int'(vec), 1);
    chk("R10", int'(width), 2);
    // R10: invalidate swizzle for int x9, destination no longer illegal
    wr_sw(1, 0, 9, 1, 8'h85);
    drive(9, 1, 1, 0, 0, 3);
    chk("R10", int'(illegal), 0);

    // config B: duplicate only in the last lane, restored entries
    wr_rt(0, 1, 5, 1, 1, 1, 20);
    wr_sw(1, 1, 9, 1, 8'h92);   // indices 2,0,1,2
    sweep("");
    // R9: duplicate outside the first SUBVL lanes is legal
    drive(9, 1, 1, 0, 0, 2);
    chk("R9", int'(illegal), 0);
    drive(9, 1, 1, 0, 0, 3);
    chk("R9", int'(illegal), 1);

    done = 1;
    finish_run();
  end
endmodule